// File: doc/BRIEF.md
# I2C Target with 16-bit Register Port

This block is an I2C bus target that runs on the system clock. It samples the SCL and SDA lines, decodes bus transactions, and turns them into single-cycle strobes on a simple register port made of an address, write data, a write strobe, a read strobe and read data. Every register is 16 bits wide and moves over the bus as two bytes, most significant byte first. An 8-bit register pointer picks the register.

A controller writes by addressing the target for write, sending the pointer byte, and then sending any number of byte pairs. For reads, it first sets the pointer the same way, then issues a repeated START and addresses the target for read. The target then returns byte pairs until the controller answers a byte with no-acknowledge. The pointer advances once per complete 16-bit register, not once per byte. The SDA pad is driven only low, through an open-drain enable.

The register port uses a synchronous read. `reg_rd` pulses with `reg_addr`, and the target samples `reg_rdata` on the following clock.

Top module: `i2c_reg16_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal 0110101 (0x6A for write, 0x6B for read, the low bit being 0 for write and 1 for read). Any other address gets no acknowledge on any later byte and produces no strobe until the next START.
- R2: In a write, the byte after the address becomes the register pointer. Each following pair of bytes (high byte, then low byte, MSB first) produces one write with `reg_addr` equal to the pointer and `reg_wdata` equal to {high, low}.
- R3: The pointer advances by one after every complete 16-bit register, for both writes and reads, and wraps from 0xFF to 0x00.
- R4: `reg_wr` is a one-cycle pulse issued only after the low byte has been acknowledged. It never coincides with `reg_rd`. A high byte left without its low byte at STOP or START is discarded and writes nothing.
- R5: After a repeated START and the read address, the target returns the register at the pointer, high byte first and MSB first. Each register is fetched by a one-cycle `reg_rd` pulse.
- R6: During a read, an acknowledge from the controller makes the target send the next byte. A no-acknowledge makes it stop driving SDA, so the controller can issue STOP.
- R7: A START at any point restarts address reception. The pointer keeps its last value.
- R8: The target changes its SDA drive only while SCL is low. It acknowledges by driving SDA low for the ninth clock of a received byte.
- R9: After reset, `sda_oe`, `reg_wr` and `reg_rd` are low.
- R10: A pulse on SCL or SDA that lasts fewer system clocks than the filter length is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 8 | Register address for a strobe |
| reg_wdata | output | 16 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench aims at the points where a byte-per-register design would go wrong. It checks pointer wrap at 0xFF: a design that increments per byte would skip every other register. It checks a lone high byte before STOP: a design that commits early would write half a register. It checks a repeated START in the middle of a write, which must leave the register untouched, and a read burst ended by no-acknowledge, after which a design that keeps sending would hold SDA and block the STOP. It also checks a foreign address followed by data, where a sloppy decoder would acknowledge or strobe, and SCL glitches during a write, which an unfiltered front end would count as extra bits.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_ACKW,
    S_ACK,
    S_SEND,
    S_MACK,
    S_LOADW
  } tgt_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)
        dout <= 1'b1;
      else if (~|win_q)
        dout <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  // SDA edges while SCL stays high mark bus conditions
  assign ev_start = scl & scl_q & sda_q & ~sda;
  assign ev_stop  = scl & scl_q & ~sda_q & sda;
  assign ev_rise  = scl & ~scl_q;
  assign ev_fall  = ~scl & scl_q;

endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2c16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int         AW       = 8,
  parameter int         DW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  localparam int BPR = DW / 8;
  localparam int BIW = (BPR > 1) ? $clog2(BPR) : 1;
  localparam logic [BIW-1:0] BIDX_LAST = BIW'(BPR - 1);

  tgt_state_t     state;
  rx_phase_t      phase;
  logic [3:0]     bitcnt;
  logic [6:0]     rx_sh;
  logic [7:0]     tx_sh;
  logic [7:0]     rx_byte;
  logic [AW-1:0]  ptr;
  logic [DW-1:0]  wacc;
  logic [DW-1:0]  rdbuf;
  logic [BIW-1:0] bidx;
  logic           rd_cap;
  logic           go_send;
  logic           wr_pend;

  assign rx_byte = {rx_sh, sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= PH_ADDR;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      wacc      <= '0;
      rdbuf     <= '0;
      bidx      <= '0;
      rd_cap    <= 1'b0;
      go_send   <= 1'b0;
      wr_pend   <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      rd_cap <= reg_rd;
      if (rd_cap)
        rdbuf <= reg_rdata;

      if (ev_start) begin
        state   <= S_RECV;
        phase   <= PH_ADDR;
        bitcnt  <= '0;
        bidx    <= '0;
        wr_pend <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (ev_stop) begin
        state   <= S_IDLE;
        wr_pend <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          S_RECV: begin
            if (ev_rise) begin
              rx_sh <= rx_byte[6:0];
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;
                state  <= S_ACKW;
                case (phase)
                  PH_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      go_send <= rx_byte[0];
                      if (rx_byte[0]) begin
                        reg_rd   <= 1'b1;
                        reg_addr <= ptr;
                        bidx     <= '0;
                      end else begin
                        phase <= PH_PTR;
                      end
                    end else begin
                      state <= S_IDLE;
                    end
                  end
                  PH_PTR: begin
                    ptr     <= rx_byte[AW-1:0];
                    phase   <= PH_DATA;
                    bidx    <= '0;
                    go_send <= 1'b0;
                  end
                  default: begin
                    wacc    <= {wacc[DW-9:0], rx_byte};
                    go_send <= 1'b0;
                    if (bidx == BIDX_LAST) begin
                      wr_pend <= 1'b1;
                      bidx    <= '0;
                    end else begin
                      bidx <= bidx + 1'b1;
                    end
                  end
                endcase
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          S_ACKW: begin
            if (ev_fall) begin
              sda_oe <= 1'b1;
              state  <= S_ACK;
            end
          end
          S_ACK: begin
            if (ev_fall) begin
              bitcnt <= '0;
              if (wr_pend) begin
                wr_pend   <= 1'b0;
                reg_wr    <= 1'b1;
                reg_addr  <= ptr;
                reg_wdata <= wacc;
                ptr       <= ptr + 1'b1;
              end
              if (go_send) begin
                sda_oe <= ~rdbuf[DW-1];
                tx_sh  <= {rdbuf[DW-2 -: 7], 1'b0};
                rdbuf  <= rdbuf << 8;
                state  <= S_SEND;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RECV;
              end
            end
          end
          S_SEND: begin
            if (ev_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                if (bidx == BIDX_LAST) begin
                  bidx     <= '0;
                  ptr      <= ptr + 1'b1;
                  reg_addr <= ptr + 1'b1;
                  reg_rd   <= 1'b1;
                end else begin
                  bidx <= bidx + 1'b1;
                end
              end
            end else if (ev_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (ev_rise)
              state <= sda ? S_IDLE : S_LOADW;
          end
          S_LOADW: begin
            if (ev_fall) begin
              bitcnt <= '0;
              sda_oe <= ~rdbuf[DW-1];
              tx_sh  <= {rdbuf[DW-2 -: 7], 1'b0};
              rdbuf  <= rdbuf << 8;
              state  <= S_SEND;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h35,
  parameter int         AW          = 8,
  parameter int         DW          = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic scl_f, sda_f;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_bus_events u_ev (
    .clk     (clk),
    .rst     (rst),
    .scl     (scl_f),
    .sda     (sda_f),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  i2c_target_core #(
    .DEV_ADDR(DEV_ADDR),
    .AW      (AW),
    .DW      (DW)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .sda      (sda_f),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata)
  );

endmodule

// File: rtl/i2c_reg16_target_chk.sv
module i2c_reg16_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic ev_stop,
  input logic sda_oe,
  input logic reg_wr,
  input logic reg_rd
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd)); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R4
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R5
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_f); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) ev_stop |=> !sda_oe); // R6

endmodule

bind i2c_reg16_target i2c_reg16_target_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_f  (scl_f),
  .ev_stop(ev_stop),
  .sda_oe (sda_oe),
  .reg_wr (reg_wr),
  .reg_rd (reg_rd)
);

// File: tb/sim_i2c_reg16_target.sv
`timescale 1ns/1ps
module sim_i2c_reg16_target;

  localparam int Q = 20;
  localparam logic [7:0] ADDR_W = 8'h6A;
  localparam logic [7:0] ADDR_R = 8'h6B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] rdata_q = '0;
  logic scl_i, sda_i;

  always #2.5 clk = ~clk;

  assign scl_i = m_scl;
  assign sda_i = m_sda & ~sda_oe;

  i2c_reg16_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(rdata_q)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  bit done = 0;
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [23:0] exp_q [$];
  logic oe_q = 1'b0;

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a]     = {a[7:0], ~a[7:0]};
      exp_mem[a] = {a[7:0], ~a[7:0]};
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // register bank stand-in with synchronous read
  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_rd) rdata_q <= mem[reg_addr];
  end

  // per-clock comparison against the expected strobe stream
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr) begin
        wr_cnt++;
        if (exp_q.size() == 0)
          chk(0, "R4", "unexpected write strobe", {8'h0, reg_addr, reg_wdata}, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R2", "write addr/data",
              {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_rd) rd_cnt++;
      if (reg_wr && reg_rd) chk(0, "R4", "wr and rd together", 1, 0);
      if (sda_oe != oe_q)
        chk(!m_scl, "R8", "SDA drive changed with SCL high", m_scl, 0);
      oe_q <= sda_oe;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    m_sda = b; wt(Q);
    m_scl = 1'b1;
    if (glitch) begin
      wt(Q/2); m_scl = 1'b0; wt(2); m_scl = 1'b1; wt(Q/2 - 2);
    end else
      wt(Q);
    m_scl = 1'b0; wt(4);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q/2);
    b = sda_i; wt(Q/2);
    m_scl = 1'b0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitch);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(~give_ack, 0);
  endtask

  task automatic do_write(input logic [7:0] p, input logic [15:0] d[$], input bit glitch);
    logic a;
    bus_start();
    send_byte(ADDR_W, glitch, a); chk(a, "R1", "write address ack", a, 1);
    send_byte(p, glitch, a);      chk(a, "R2", "pointer ack", a, 1);
    for (int k = 0; k < d.size(); k++) begin
      logic [7:0] idx;
      idx = p + k[7:0];
      exp_q.push_back({idx, d[k]});
      exp_mem[idx] = d[k];
      send_byte(d[k][15:8], glitch, a); chk(a, "R2", "high byte ack", a, 1);
      send_byte(d[k][7:0], glitch, a);  chk(a, "R2", "low byte ack", a, 1);
    end
    bus_stop();
    wt(20);
    chk(exp_q.size() == 0, glitch ? "R10" : "R4", "write strobes outstanding",
        exp_q.size(), 0);
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input string tag);
    logic a;
    logic [7:0] hi, lo;
    bus_start();
    send_byte(ADDR_W, 0, a); chk(a, "R1", "address ack", a, 1);
    send_byte(p, 0, a);      chk(a, "R2", "pointer ack", a, 1);
    bus_start();
    send_byte(ADDR_R, 0, a); chk(a, "R5", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] idx;
      idx = p + k[7:0];
      recv_byte(hi, 1'b1);
      recv_byte(lo, k != n - 1);
      chk({hi, lo} == exp_mem[idx], (k == 0) ? "R5" : tag, "read data",
          {hi, lo}, exp_mem[idx]);
    end
    wt(Q);
    chk(sda_oe == 1'b0, "R6", "SDA released after no-ack", sda_oe, 0);
    bus_stop();
    wt(20);
  endtask

  initial begin
    logic a;
    logic [7:0] hi, lo;
    int w0, r0;
    wt(5);
    rst = 1'b0;
    wt(2);
    chk(sda_oe == 1'b0, "R9", "sda_oe after reset", sda_oe, 0);
    chk(reg_wr == 1'b0, "R9", "reg_wr after reset", reg_wr, 0);
    chk(reg_rd == 1'b0, "R9", "reg_rd after reset", reg_rd, 0);
    wt(20);

    // burst write and read back
    do_write(8'h10, '{16'hBEEF, 16'h0123, 16'h8001}, 0);
    do_read(8'h10, 3, "R3");

    // foreign address
    w0 = wr_cnt; r0 = rd_cnt;
    bus_start();
    send_byte(8'h6C, 0, a); chk(!a, "R1", "foreign address not acked", a, 0);
    send_byte(8'h10, 0, a); chk(!a, "R1", "byte after foreign address", a, 0);
    send_byte(8'h55, 0, a); chk(!a, "R1", "data after foreign address", a, 0);
    send_byte(8'hAA, 0, a);
    bus_stop(); wt(20);
    chk(wr_cnt == w0 && rd_cnt == r0, "R1", "strobes after foreign address",
        wr_cnt - w0 + rd_cnt - r0, 0);

    // pointer wrap
    do_write(8'hFF, '{16'hA5A5, 16'h5A5A}, 0);
    do_read(8'hFF, 2, "R3");

    // dangling high byte before STOP
    w0 = wr_cnt;
    bus_start();
    send_byte(ADDR_W, 0, a);
    send_byte(8'h20, 0, a);
    exp_q.push_back({8'h20, 16'h1234}); exp_mem[8'h20] = 16'h1234;
    send_byte(8'h12, 0, a);
    send_byte(8'h34, 0, a);
    send_byte(8'h77, 0, a);
    bus_stop(); wt(20);
    chk(wr_cnt == w0 + 1, "R4", "strobes with dangling high byte", wr_cnt - w0, 1);
    do_read(8'h20, 2, "R4");

    // repeated START in the middle of a write
    w0 = wr_cnt;
    bus_start();
    send_byte(ADDR_W, 0, a);
    send_byte(8'h40, 0, a);
    send_byte(8'h99, 0, a);
    bus_start();
    send_byte(ADDR_R, 0, a); chk(a, "R7", "address after mid-write START", a, 1);
    recv_byte(hi, 1'b1);
    recv_byte(lo, 1'b0);
    chk({hi, lo} == exp_mem[8'h40], "R7", "pointer kept across START",
        {hi, lo}, exp_mem[8'h40]);
    bus_stop(); wt(20);
    chk(wr_cnt == w0, "R4", "no write from cut pair", wr_cnt - w0, 0);

    // glitches on SCL during a write
    do_write(8'h50, '{16'hC3C3, 16'h0F0F}, 1);
    do_read(8'h50, 2, "R10");

    finish_run();
  end

  initial begin
    wt(150000);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

endmodule